// File: doc/BRIEF.md
# Pipelined ADC Scan Sequencer

This block drives a multi-channel successive-approximation converter over a four-wire serial link. The converter takes one 16-bit command word per chip-select window and returns the result of a command two windows later. A host loads a channel enable mask and pulses a start strobe. The sequencer then sends one conversion command for each enabled channel, lowest channel first. It follows these with two all-zero words that push the last results out of the converter's pipeline.

Each returned word carries the channel number in its top nibble and a left-justified sample below it. The sequencer pairs every returned word with the channel it requested two frames earlier. It extracts the sample at the configured resolution and flags a tag mismatch. It presents the result on a valid/ready port. A held sample stops the next frame from starting, so a slow consumer throttles the serial link and no results are lost.

Top module: `adc_scan_seq`

## Requirements
- R1: Each frame is 16 bits, MSB first, in mode 0. `mosi_o` changes only while `sclk_o` is low, `miso_i` is sampled on the rising edge, and `sclk_o` is low whenever `cs_no` is high.
- R2: Between two frames, `cs_no` stays high for at least one SCLK period, which is 2*HALF_DIV clock cycles.
- R3: A conversion command sets bit 12 to 1 and carries the channel number in bits 10:7. All other bits are 0. Commands go out in ascending channel order, and only for channels enabled in the mask.
- R4: After the last command come two all-zero frames. A scan therefore uses popcount(mask)+2 frames.
- R5: The words received in the first two frames of a scan are discarded. The word received in frame N+2 is reported as the result for the channel commanded in frame N, with that channel on `smp_ch_o`.
- R6: `smp_data_o` is bits 11 down to 12-RES_BITS of the received word.
- R7: `smp_err_o` is 1 exactly when bits 15:12 of the received word differ from the channel that was requested.
- R8: While `smp_valid_o` is 1 and `smp_ready_i` is 0, the sample outputs hold their values. No new frame starts while a sample is waiting to be taken.
- R9: A start pulse while `busy_o` is 1 is ignored, together with the mask presented with it.
- R10: `done_o` pulses for one cycle at the end of the final flush frame. `busy_o` is 0 in that same cycle.
- R11: A start with an empty mask pulses `done_o` in the next cycle and sends no frame.
- R12: After reset, `cs_no` is 1, and `sclk_o`, `busy_o`, `smp_valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start strobe |
| ch_mask_i | input | NUM_CH | Channel enable mask, sampled with start |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial command out |
| miso_i | input | 1 | Serial result in |
| smp_valid_o | output | 1 | Sample available |
| smp_ready_i | input | 1 | Consumer accepts sample |
| smp_ch_o | output | 4 | Channel the sample was requested for |
| smp_data_o | output | RES_BITS | Sample value |
| smp_err_o | output | 1 | Returned tag differs from requested channel |

## Verification
On every cycle, the assertions check that the serial clock is idle while the chip is deselected, and that the chip-select high gap is kept. They also check that a held sample stays stable and is never overwritten, that the done pulse is single and coincides with idle, and that the bus stays quiet whenever the block is idle. Only the bench's scenarios can show the rest. These are the exact command sequence decoded off the wire, the two-frame lag between a command and its result, the discard of the first two words, and tag-error marking. They also include the stall of the link under a held sample, and whether a start while busy or an empty mask really leaves the frame count untouched.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W = 16;
  localparam int CH_W    = 4;

  typedef struct packed {
    logic            vld;
    logic [CH_W-1:0] ch;
  } tag_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT} seq_st_e;
  typedef enum logic [2:0] {FR_IDLE, FR_LEAD, FR_HIGH, FR_LOW, FR_GAP} fr_st_e;

  function automatic logic [FRAME_W-1:0] mk_conv_cmd(logic [CH_W-1:0] ch);
    return {3'b000, 1'b1, 1'b0, ch, 7'b0};
  endfunction
endpackage

// File: rtl/adc_lowest_pick.sv
module adc_lowest_pick #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] mask_i,
  output logic [3:0]        idx_o,
  output logic              any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = 4'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  fr_st_e             st_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic               gap_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic               tick;

  assign tick      = (div_q == DIV_W'(HALF_DIV - 1));
  assign mosi_o    = tx_q[FRAME_W-1];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      gap_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == FR_IDLE) div_q <= '0;
      else div_q <= tick ? '0 : div_q + 1'b1;
      unique case (st_q)
        FR_IDLE: if (go_i) begin
          cs_no <= 1'b0;
          tx_q  <= tx_word_i;
          st_q  <= FR_LEAD;
        end
        FR_LEAD, FR_LOW: if (tick) begin
          sclk_o <= 1'b1;
          rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
          st_q   <= FR_HIGH;
        end
        FR_HIGH: if (tick) begin
          sclk_o <= 1'b0;
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            cs_no <= 1'b1;
            bit_q <= '0;
            gap_q <= 1'b0;
            st_q  <= FR_GAP;
          end else begin
            tx_q  <= tx_q << 1;
            bit_q <= bit_q + 1'b1;
            st_q  <= FR_LOW;
          end
        end
        FR_GAP: if (tick) begin
          if (gap_q) begin
            st_q   <= FR_IDLE;
            done_o <= 1'b1;
          end else gap_q <= 1'b1;
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  assert_mosi_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o) |-> $stable(mosi_o));
  assert_cs_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> ($past(cs_no, 1) && $past(cs_no, 2)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int HALF_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_CH-1:0]   ch_mask_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                smp_valid_o,
  input  logic                smp_ready_i,
  output logic [CH_W-1:0]     smp_ch_o,
  output logic [RES_BITS-1:0] smp_data_o,
  output logic                smp_err_o
);
  localparam int FLUSH_FRAMES = 2;
  localparam int LAG          = 3;

  seq_st_e            st_q;
  logic [NUM_CH-1:0]  pend_q;
  logic [1:0]         flush_q;
  tag_t [LAG-1:0]     pipe_q;
  logic [CH_W-1:0]    pick_idx;
  logic               pick_any;
  logic               frame_go, frame_done;
  logic [FRAME_W-1:0] cmd_word, rx_word;
  tag_t               new_tag;

  adc_lowest_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask_i (pend_q),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign frame_go = (st_q == SQ_LAUNCH) && !smp_valid_o;
  assign cmd_word = pick_any ? mk_conv_cmd(pick_idx) : '0;
  assign new_tag  = '{vld: pick_any, ch: pick_idx};
  assign busy_o   = (st_q != SQ_IDLE);

  adc_spi_frame #(.HALF_DIV(HALF_DIV)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (frame_go),
    .tx_word_i (cmd_word),
    .done_o    (frame_done),
    .rx_word_o (rx_word),
    .sclk_o    (sclk_o),
    .cs_no     (cs_no),
    .mosi_o    (mosi_o),
    .miso_i    (miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      pend_q  <= '0;
      flush_q <= '0;
      pipe_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          if (ch_mask_i == '0) done_o <= 1'b1;
          else begin
            pend_q  <= ch_mask_i;
            flush_q <= 2'(FLUSH_FRAMES);
            pipe_q  <= '0;
            st_q    <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: if (frame_go) begin
          if (pick_any) pend_q <= pend_q & (pend_q - 1'b1);
          else flush_q <= flush_q - 1'b1;
          pipe_q <= {pipe_q[LAG-2:0], new_tag};
          st_q   <= SQ_WAIT;
        end
        SQ_WAIT: if (frame_done) begin
          if (pend_q == '0 && flush_q == '0) begin
            done_o <= 1'b1;
            st_q   <= SQ_IDLE;
          end else st_q <= SQ_LAUNCH;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // oldest pipe entry is the command whose result arrives now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_valid_o <= 1'b0;
      smp_ch_o    <= '0;
      smp_data_o  <= '0;
      smp_err_o   <= 1'b0;
    end else if (frame_done && pipe_q[LAG-1].vld) begin
      smp_valid_o <= 1'b1;
      smp_ch_o    <= pipe_q[LAG-1].ch;
      smp_data_o  <= rx_word[FRAME_W-5 -: RES_BITS];
      smp_err_o   <= (rx_word[FRAME_W-1 -: CH_W] != pipe_q[LAG-1].ch);
    end else if (smp_ready_i) begin
      smp_valid_o <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_data_o)
      && $stable(smp_ch_o) && $stable(smp_err_o)));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && pipe_q[LAG-1].vld) |-> !smp_valid_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_bus_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o));
  assert_cmd_fmt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_go |-> (cmd_word[15:13] == 3'b0 && !cmd_word[11] && cmd_word[6:0] == 7'b0));
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 16;
  localparam int RES        = 12;
  localparam int HALF       = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NUM_CH-1:0] ch_mask_i = '0;
  logic busy_o, done_o, sclk_o, cs_no, mosi_o;
  logic miso_i = 1'b0;
  logic smp_valid_o, smp_ready_i = 1'b1, smp_err_o;
  logic [3:0] smp_ch_o;
  logic [RES-1:0] smp_data_o;

  int total = 0, bad = 0;
  int frames = 0, bad_ch = -1, seed = 0, rdy_mode = 0, cyc = 0, hi_run = 1000;
  int ecmd[24];
  int nexp = 0;
  int iss[24];
  int q_ch[$], q_dat[$], q_err[$];
  logic [15:0] s_tx = '0, s_rx = '0;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_BITS(RES), .HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ch_mask_i(ch_mask_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .miso_i(miso_i), .smp_valid_o(smp_valid_o),
    .smp_ready_i(smp_ready_i), .smp_ch_o(smp_ch_o), .smp_data_o(smp_data_o),
    .smp_err_o(smp_err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(int ch);
    int tag;
    tag = (ch == bad_ch) ? (ch ^ 1) : ch;
    return {4'(tag), 12'((seed + ch * 37) & 12'hFFF)};
  endfunction

  // converter model: result of frame k-2 returned in frame k
  always @(negedge cs_no) begin
    s_rx = '0;
    if (frames >= 2 && frames < 24 && iss[frames-2] >= 0) s_tx = resp(iss[frames-2]);
    else s_tx = 16'hC3A5;
    miso_i = s_tx[15];
  end
  always @(negedge sclk_o) if (!cs_no) begin
    s_tx = s_tx << 1;
    miso_i = s_tx[15];
  end
  always @(posedge sclk_o) if (!cs_no) s_rx = {s_rx[14:0], mosi_o};
  always @(posedge cs_no) if (rst_ni) begin
    if (frames < nexp) chk(s_rx == 16'(ecmd[frames]), "R3/R4", "command word", s_rx, ecmd[frames]);
    else chk(0, "R4", "extra frame", frames, nexp);
    if (frames < 24) iss[frames] = s_rx[12] ? int'(s_rx[10:7]) : -1;
    frames++;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    smp_ready_i <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  // per-clock reference compare
  always @(negedge clk) if (rst_ni) begin
    if (cs_no && sclk_o) chk(0, "R1", "sclk high while deselected", 1, 0);
    if (cs_no) hi_run++;
    else begin
      if (hi_run > 0) chk(hi_run >= 2 * HALF, "R2", "cs high gap", hi_run, 2 * HALF);
      hi_run = 0;
    end
    if (smp_valid_o && smp_ready_i) begin
      if (q_ch.size() == 0) chk(0, "R5", "unexpected sample", smp_ch_o, -1);
      else begin
        chk(smp_ch_o == 4'(q_ch[0]), "R5", "sample channel", smp_ch_o, q_ch[0]);
        chk(smp_data_o == RES'(q_dat[0]), "R6", "sample data", smp_data_o, q_dat[0]);
        chk(smp_err_o == q_err[0][0], "R7", "tag error flag", smp_err_o, q_err[0]);
        void'(q_ch.pop_front()); void'(q_dat.pop_front()); void'(q_err.pop_front());
      end
    end
  end

  task automatic run_scan(logic [15:0] mask, int mode, int badc, bit stall, bit poke);
    int n, f0, w;
    logic [15:0] d;
    logic [RES-1:0] dres;
    bad_ch = badc; seed = seed + 211; rdy_mode = stall ? 2 : mode;
    n = 0;
    for (int c = 0; c < NUM_CH; c++) if (mask[c]) begin
      ecmd[n] = 32'h1000 | (c << 7);
      d = resp(c);
      dres = d[11 -: RES];
      q_ch.push_back(c); q_dat.push_back(int'(dres)); q_err.push_back(c == badc);
      n++;
    end
    ecmd[n] = 0; ecmd[n+1] = 0; nexp = n + 2;
    for (int k = 0; k < 24; k++) iss[k] = -1;
    frames = 0;
    @(negedge clk); start_i = 1'b1; ch_mask_i = NUM_CH'(mask);
    @(negedge clk); start_i = 1'b0; ch_mask_i = '0;
    if (poke) begin
      repeat (50) @(negedge clk);
      chk(busy_o == 1'b1, "R9", "busy during scan", busy_o, 1);
      start_i = 1'b1; ch_mask_i = '1;
      @(negedge clk); start_i = 1'b0; ch_mask_i = '0;
    end
    if (stall) begin
      w = 0;
      while (!smp_valid_o && w < 5000) begin @(negedge clk); w++; end
      f0 = frames;
      repeat (300) @(negedge clk);
      chk(frames == f0, "R8", "frames during stall", frames, f0);
      chk(smp_valid_o == 1'b1, "R8", "sample held", smp_valid_o, 1);
      rdy_mode = mode;
    end
    w = 0;
    while (!done_o && w < 20000) begin @(negedge clk); w++; end
    chk(done_o == 1'b1, "R10", "done pulse", done_o, 1);
    chk(busy_o == 1'b0, "R10", "idle at done", busy_o, 0);
    chk(frames == n + 2, "R4", "frame count", frames, n + 2);
    @(negedge clk);
    chk(done_o == 1'b0, "R10", "done single cycle", done_o, 0);
    repeat (20) @(negedge clk);
    chk(q_ch.size() == 0, "R5", "samples outstanding", q_ch.size(), 0);
    q_ch.delete(); q_dat.delete(); q_err.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_no == 1'b1, "R12", "reset cs", cs_no, 1);
    chk(sclk_o == 1'b0, "R12", "reset sclk", sclk_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R12", "reset busy/done", busy_o, 0);
    chk(smp_valid_o == 1'b0, "R12", "reset valid", smp_valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    run_scan(16'hFFFF, 0, -1, 0, 0);   // R1 R3 R5 R6: full scan
    run_scan(16'h8421, 1, -1, 0, 0);   // R8: throttled consumer
    run_scan(16'h0001, 0, -1, 0, 0);   // R4: lowest single channel
    run_scan(16'h8000, 1, -1, 0, 0);   // R4: highest single channel
    run_scan(16'h00F0, 0, 5, 0, 0);    // R7: corrupted tag on channel 5
    run_scan(16'h0007, 0, -1, 1, 0);   // R8: stall
    run_scan(16'h0030, 0, -1, 0, 1);   // R9: start while busy
    // R11: empty mask
    frames = 0;
    @(negedge clk); start_i = 1'b1; ch_mask_i = '0;
    @(negedge clk); start_i = 1'b0;
    chk(done_o == 1'b1, "R11", "empty mask done", done_o, 1);
    chk(busy_o == 1'b0, "R11", "empty mask idle", busy_o, 0);
    repeat (100) @(negedge clk);
    chk(frames == 0, "R11", "empty mask frames", frames, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule